// File: doc/BRIEF.md
# Bridge Uncorrectable Write-Data Error Reaction

This block decides how a bridge reacts when it sees corrupted data on a non-posted write that enters from the conventional PCI side and is headed upstream to PCI Express. One strobe reports the error together with the captured packet header. From a handful of configuration bits the block then chooses between two paths. In the first, the write is dropped and the PCI parity error line is driven. In the second, the write is forwarded upstream with its data marked as poisoned.

On the same strobe the block updates a set of sticky status bits. If the error is unmasked and no earlier error is still recorded, it stores the header in a log and sets a first-error pointer. It also raises a request for a fatal or non-fatal error message, as the error's severity bit directs. Software clears the status bits by writing ones. Clearing the uncorrectable-error bit re-arms the pointer so that the next error can be logged. The message request is a one-cycle pulse. The request then counts as outstanding until the message engine acknowledges it.

Top module: `ude_react`

## Requirements
- R1: After reset, every output is 0: the path controls, `sts`, `log_we`, `log_hdr`, `eptr_valid`, `msg_req` and `msg_fatal`.
- R2: When `err_det` is high and `cfg_path_perr` is 1, `wr_discard` and `perr_out` are high and `wr_poison` is low during the next cycle only.
- R3: When `err_det` is high and `cfg_path_perr` is 0, `wr_poison` is high and `wr_discard` and `perr_out` are low during the next cycle only. On this path the master-data-parity status bit `sts[1]` is set only if `cfg_pri_perr` is 1.
- R4: Every `err_det` sets the uncorrectable-error status bit `sts[0]`.
- R5: An error is logged only when `cfg_ude_mask` is 0 and `eptr_valid` is 0. A logged error pulses `log_we` for one cycle, loads `err_hdr` into `log_hdr` and sets `eptr_valid`. Any other error leaves `log_hdr` unchanged and does not pulse `log_we`.
- R6: An error qualifies for a message when `cfg_ude_mask` is 0 and either `cfg_serr_en` is 1 or the enable chosen by severity is 1 (`cfg_fatal_en` when `cfg_ude_fatal` is 1, `cfg_nonfatal_en` otherwise). When the message is issued, `msg_req` pulses for one cycle and `msg_fatal` equals `cfg_ude_fatal`.
- R7: The signaled-system-error bit `sts[2]` is set only by an error that qualifies for a message while `cfg_serr_en` is 1.
- R8: Each error sets `sts[3]` (fatal detected) when `cfg_ude_fatal` is 1, and sets `sts[4]` (non-fatal detected) otherwise.
- R9: Status bits are sticky. A 1 on `sts_clr[i]` clears `sts[i]` at the next edge. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: A 1 on `sts_clr[0]` clears `eptr_valid`. An error in that same cycle sees the pointer as free and is logged when unmasked.
- R11: After a `msg_req`, a request stays outstanding until `msg_ack`. A qualifying error that arrives while a request is outstanding issues no `msg_req`, although its status bits are still set. An error in the cycle of the acknowledge is issued (parameter `ACK_REISSUE` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_det | input | 1 | Uncorrectable write-data error strobe |
| err_hdr | input | HDR_DW*DW_BITS | Header of the failing write |
| cfg_path_perr | input | 1 | 1 selects discard with parity error, 0 selects poison-forward |
| cfg_pri_perr | input | 1 | Upstream parity-response enable, gates `sts[1]` |
| cfg_serr_en | input | 1 | System-error enable |
| cfg_fatal_en | input | 1 | Fatal reporting enable |
| cfg_nonfatal_en | input | 1 | Non-fatal reporting enable |
| cfg_ude_mask | input | 1 | Mask for this error |
| cfg_ude_fatal | input | 1 | Severity, 1 = fatal |
| sts_clr | input | 5 | Write-one-to-clear strobes, one per status bit |
| msg_ack | input | 1 | Message engine acknowledge |
| wr_discard | output | 1 | Drop the write (pulse) |
| wr_poison | output | 1 | Forward the write poisoned (pulse) |
| perr_out | output | 1 | Drive PCI parity error (pulse) |
| sts | output | 5 | Sticky status: [0] uncorrectable, [1] master parity, [2] system error signaled, [3] fatal detected, [4] non-fatal detected |
| log_we | output | 1 | Header log write pulse |
| log_hdr | output | HDR_DW*DW_BITS | Logged header |
| eptr_valid | output | 1 | First-error pointer valid |
| msg_req | output | 1 | Error message request pulse |
| msg_fatal | output | 1 | Severity of the requested message |

## Verification
Two collisions matter most: a write-one-to-clear of the uncorrectable bit in the same cycle as a new error, and an acknowledge of an outstanding message in the same cycle as a new qualifying error. The bench drives both events at the same negative edge. In the first case it expects the status bit to stay set, the new header to be logged and the pointer to be valid. In the second it expects a fresh `msg_req` in the very next cycle. A sweep over all 128 combinations of the seven configuration bits checks the path, status, log and message decisions against expected values that the bench computes itself.

// File: rtl/ude_pkg.sv
package ude_pkg;
   localparam int STS_N     = 5;
   localparam int STS_UDE   = 0;
   localparam int STS_MDPE  = 1;
   localparam int STS_SSE   = 2;
   localparam int STS_FDET  = 3;
   localparam int STS_NFDET = 4;

   typedef struct packed {
      logic discard;
      logic poison;
      logic perr;
      logic log_take;
      logic msg_want;
      logic msg_sev;
      logic [STS_N-1:0] sts_set;
   } ude_act_t;
endpackage

// File: rtl/ude_decide.sv
module ude_decide
   import ude_pkg::*;
(
   input  logic     err_det,
   input  logic     eptr_busy,
   input  logic     cfg_path_perr,
   input  logic     cfg_pri_perr,
   input  logic     cfg_serr_en,
   input  logic     cfg_fatal_en,
   input  logic     cfg_nonfatal_en,
   input  logic     cfg_ude_mask,
   input  logic     cfg_ude_fatal,
   output ude_act_t act
);
   logic rpt_en;
   logic qualifies;

   always_comb begin
      rpt_en    = cfg_ude_fatal ? cfg_fatal_en : cfg_nonfatal_en;
      qualifies = ~cfg_ude_mask & (cfg_serr_en | rpt_en);
      act = '0;
      if (err_det) begin
         act.discard            = cfg_path_perr;
         act.perr               = cfg_path_perr;
         act.poison             = ~cfg_path_perr;
         act.log_take           = ~cfg_ude_mask & ~eptr_busy;
         act.msg_want           = qualifies;
         act.msg_sev            = cfg_ude_fatal;
         act.sts_set[STS_UDE]   = 1'b1;
         act.sts_set[STS_MDPE]  = ~cfg_path_perr & cfg_pri_perr;
         act.sts_set[STS_SSE]   = qualifies & cfg_serr_en;
         act.sts_set[STS_FDET]  = cfg_ude_fatal;
         act.sts_set[STS_NFDET] = ~cfg_ude_fatal;
      end
   end
endmodule

// File: rtl/ude_sticky_sts.sv
module ude_sticky_sts #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q
);
   initial begin
      if (N < 1) $error("ude_sticky_sts: N must be positive");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          q[b] <= 1'b0;
         else if (set_i[b])   q[b] <= 1'b1;
         else if (clr_i[b])   q[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/ude_hdr_log.sv
module ude_hdr_log #(
   parameter int HDR_W = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             rearm,
   input  logic [HDR_W-1:0] hdr_i,
   output logic             we_o,
   output logic [HDR_W-1:0] hdr_o,
   output logic             valid_o
);
   initial begin
      if (HDR_W < 32) $error("ude_hdr_log: header narrower than one word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_o    <= 1'b0;
         hdr_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         we_o <= take;
         if (take) begin
            hdr_o   <= hdr_i;
            valid_o <= 1'b1;
         end else if (rearm) begin
            valid_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ude_msg_gen.sv
module ude_msg_gen #(
   parameter bit ACK_REISSUE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic sev,
   input  logic ack,
   output logic req_o,
   output logic fatal_o
);
   logic pend;
   logic free;
   logic issue;

   if (ACK_REISSUE) begin : g_reissue
      assign free = ~pend | ack;
   end else begin : g_strict
      assign free = ~pend;
   end

   assign issue = want & free;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         req_o   <= 1'b0;
         fatal_o <= 1'b0;
      end else begin
         req_o <= issue;
         if (issue)      pend <= 1'b1;
         else if (ack)   pend <= 1'b0;
         if (issue)      fatal_o <= sev;
      end
   end
endmodule

// File: rtl/ude_react.sv
module ude_react
   import ude_pkg::*;
#(
   parameter int HDR_DW      = 3,
   parameter int DW_BITS     = 32,
   parameter bit ACK_REISSUE = 1'b1,
   localparam int HDR_W      = HDR_DW * DW_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_det,
   input  logic [HDR_W-1:0] err_hdr,
   input  logic             cfg_path_perr,
   input  logic             cfg_pri_perr,
   input  logic             cfg_serr_en,
   input  logic             cfg_fatal_en,
   input  logic             cfg_nonfatal_en,
   input  logic             cfg_ude_mask,
   input  logic             cfg_ude_fatal,
   input  logic [4:0]       sts_clr,
   input  logic             msg_ack,
   output logic             wr_discard,
   output logic             wr_poison,
   output logic             perr_out,
   output logic [4:0]       sts,
   output logic             log_we,
   output logic [HDR_W-1:0] log_hdr,
   output logic             eptr_valid,
   output logic             msg_req,
   output logic             msg_fatal
);
   initial begin
      if (HDR_DW < 3 || HDR_DW > 4) $error("ude_react: HDR_DW must be 3 or 4");
      if (DW_BITS != 32)            $error("ude_react: DW_BITS must be 32");
      if (STS_N != 5)               $error("ude_react: status width mismatch");
   end

   ude_act_t act;
   logic     eptr_busy;

   assign eptr_busy = eptr_valid & ~sts_clr[STS_UDE];

   ude_decide u_decide (
      .err_det         (err_det),
      .eptr_busy       (eptr_busy),
      .cfg_path_perr   (cfg_path_perr),
      .cfg_pri_perr    (cfg_pri_perr),
      .cfg_serr_en     (cfg_serr_en),
      .cfg_fatal_en    (cfg_fatal_en),
      .cfg_nonfatal_en (cfg_nonfatal_en),
      .cfg_ude_mask    (cfg_ude_mask),
      .cfg_ude_fatal   (cfg_ude_fatal),
      .act             (act)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_discard <= 1'b0;
         wr_poison  <= 1'b0;
         perr_out   <= 1'b0;
      end else begin
         wr_discard <= act.discard;
         wr_poison  <= act.poison;
         perr_out   <= act.perr;
      end
   end

   ude_sticky_sts #(.N(STS_N)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (act.sts_set),
      .clr_i (sts_clr),
      .q     (sts)
   );

   ude_hdr_log #(.HDR_W(HDR_W)) u_log (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (act.log_take),
      .rearm   (sts_clr[STS_UDE]),
      .hdr_i   (err_hdr),
      .we_o    (log_we),
      .hdr_o   (log_hdr),
      .valid_o (eptr_valid)
   );

   ude_msg_gen #(.ACK_REISSUE(ACK_REISSUE)) u_msg (
      .clk     (clk),
      .rst_n   (rst_n),
      .want    (act.msg_want),
      .sev     (act.msg_sev),
      .ack     (msg_ack),
      .req_o   (msg_req),
      .fatal_o (msg_fatal)
   );
endmodule

// File: rtl/ude_react_chk.sv
module ude_react_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       err_det,
   input logic       cfg_path_perr,
   input logic       cfg_serr_en,
   input logic       cfg_ude_mask,
   input logic [4:0] sts_clr,
   input logic       wr_discard,
   input logic       wr_poison,
   input logic       perr_out,
   input logic [4:0] sts,
   input logic       log_we,
   input logic       eptr_valid,
   input logic       msg_req
);
   AST_PATH_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      err_det |=> (wr_discard == $past(cfg_path_perr)));                   // R2
   AST_POISON_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_poison |-> (!perr_out && !wr_discard));                           // R3
   AST_UDE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      err_det |=> sts[0]);                                                 // R4
   AST_LOG_SETS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      log_we |-> eptr_valid);                                              // R5
   AST_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_det && eptr_valid && !sts_clr[0]) |=> !log_we);                 // R5
   AST_MASK_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      (err_det && cfg_ude_mask) |=> !msg_req);                             // R6
   AST_SSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[2]) |-> $past(cfg_serr_en));                               // R7
   AST_CLR_WITHOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_det && sts_clr[3]) |=> !sts[3]);                               // R9
endmodule

bind ude_react ude_react_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .err_det       (err_det),
   .cfg_path_perr (cfg_path_perr),
   .cfg_serr_en   (cfg_serr_en),
   .cfg_ude_mask  (cfg_ude_mask),
   .sts_clr       (sts_clr),
   .wr_discard    (wr_discard),
   .wr_poison     (wr_poison),
   .perr_out      (perr_out),
   .sts           (sts),
   .log_we        (log_we),
   .eptr_valid    (eptr_valid),
   .msg_req       (msg_req)
);

// File: tb/ude_react_tb.sv
module ude_react_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HDR_W = 96;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             err_det = 1'b0;
   logic [HDR_W-1:0] err_hdr = '0;
   logic cfg_path_perr = 0, cfg_pri_perr = 0, cfg_serr_en = 0, cfg_fatal_en = 0;
   logic cfg_nonfatal_en = 0, cfg_ude_mask = 0, cfg_ude_fatal = 0;
   logic [4:0]       sts_clr = '0;
   logic             msg_ack = 1'b0;
   logic             wr_discard, wr_poison, perr_out, log_we, eptr_valid, msg_req, msg_fatal;
   logic [4:0]       sts;
   logic [HDR_W-1:0] log_hdr;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ude_react u_dut (
      .clk(clk), .rst_n(rst_n), .err_det(err_det), .err_hdr(err_hdr),
      .cfg_path_perr(cfg_path_perr), .cfg_pri_perr(cfg_pri_perr),
      .cfg_serr_en(cfg_serr_en), .cfg_fatal_en(cfg_fatal_en),
      .cfg_nonfatal_en(cfg_nonfatal_en), .cfg_ude_mask(cfg_ude_mask),
      .cfg_ude_fatal(cfg_ude_fatal), .sts_clr(sts_clr), .msg_ack(msg_ack),
      .wr_discard(wr_discard), .wr_poison(wr_poison), .perr_out(perr_out),
      .sts(sts), .log_we(log_we), .log_hdr(log_hdr), .eptr_valid(eptr_valid),
      .msg_req(msg_req), .msg_fatal(msg_fatal)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic e, input logic [HDR_W-1:0] h,
                       input logic [4:0] c, input logic a);
      @(negedge clk);
      err_det = e; err_hdr = h; sts_clr = c; msg_ack = a;
      @(posedge clk);
      #1;
      @(negedge clk);
      err_det = 1'b0; sts_clr = '0; msg_ack = 1'b0;
   endtask

   task automatic step_keep(input logic e, input logic [HDR_W-1:0] h,
                            input logic [4:0] c, input logic a);
      @(negedge clk);
      err_det = e; err_hdr = h; sts_clr = c; msg_ack = a;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [HDR_W-1:0] exp_log;
      logic [HDR_W-1:0] ha, hb, hc;
      exp_log = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R1 path", {wr_discard, wr_poison, perr_out}, 0);
      chk("R1 sts", sts, 0);
      chk("R1 log", {log_we, eptr_valid, log_hdr}, 0);
      chk("R1 msg", {msg_req, msg_fatal}, 0);

      for (int i = 0; i < 128; i++) begin
         logic brg, pri, serr, fen, nfen, msk, sev, q;
         logic [HDR_W-1:0] h;
         logic [4:0] es;
         brg = i[0]; pri = i[1]; serr = i[2]; fen = i[3];
         nfen = i[4]; msk = i[5]; sev = i[6];
         q = !msk && (serr || (sev ? fen : nfen));
         h = {32'(i * 3 + 1), 32'(i * 5 + 2), 32'(i * 7 + 3)};
         step_keep(1'b0, '0, 5'h1f, 1'b1);
         chk("R9 clear all", sts, 0);
         chk("R10 rearm", eptr_valid, 0);
         @(negedge clk);
         sts_clr = '0; msg_ack = 1'b0;
         cfg_path_perr = brg; cfg_pri_perr = pri; cfg_serr_en = serr;
         cfg_fatal_en = fen; cfg_nonfatal_en = nfen; cfg_ude_mask = msk; cfg_ude_fatal = sev;
         err_det = 1'b1; err_hdr = h;
         @(posedge clk);
         #1;
         es = {!sev, sev, q && serr, !brg && pri, 1'b1};
         if (!msk) exp_log = h;
         chk("R2 discard/perr", {wr_discard, perr_out}, {brg, brg});
         chk("R3 poison", wr_poison, !brg);
         chk("R3 R4 R7 R8 status", sts, es);
         chk("R5 log_we", {log_we, eptr_valid}, {!msk, !msk});
         chk("R5 log_hdr", log_hdr, exp_log);
         chk("R6 msg_req", msg_req, q);
         if (q) chk("R6 msg_fatal", msg_fatal, sev);
         @(negedge clk);
         err_det = 1'b0;
         @(posedge clk);
         #1;
         chk("R2 R3 pulse ends", {wr_discard, wr_poison, perr_out, log_we, msg_req}, 0);
         chk("R9 sticky", sts, es);
      end

      // Directed: second error while the pointer is valid (R5)
      cfg_path_perr = 0; cfg_pri_perr = 0; cfg_serr_en = 1; cfg_fatal_en = 0;
      cfg_nonfatal_en = 0; cfg_ude_mask = 0; cfg_ude_fatal = 1;
      ha = {3{32'hA1A1_0001}}; hb = {3{32'hB2B2_0002}}; hc = {3{32'hC3C3_0003}};
      step(1'b0, '0, 5'h1f, 1'b1);
      step_keep(1'b1, ha, 5'h00, 1'b0);
      chk("R5 first logged", {log_we, log_hdr}, {1'b1, ha});
      step_keep(1'b1, hb, 5'h00, 1'b1);
      chk("R5 second kept out", {log_we, log_hdr, eptr_valid}, {1'b0, ha, 1'b1});
      chk("R4 second sets status", sts[0], 1'b1);
      // Collision: clear of bit 0 with a new error (R9, R10)
      step_keep(1'b1, hc, 5'h01, 1'b1);
      chk("R9 set wins", sts[0], 1'b1);
      chk("R10 same-cycle log", {log_we, log_hdr, eptr_valid}, {1'b1, hc, 1'b1});
      // Clear alone (R9, R10)
      step_keep(1'b0, '0, 5'h09, 1'b1);
      chk("R9 clear bits 0,3", {sts[3], sts[0]}, 2'b00);
      chk("R9 others held", sts[2], 1'b1);
      chk("R10 pointer freed", eptr_valid, 1'b0);
      chk("R5 log unchanged", log_hdr, hc);

      // Message pending (R11)
      step(1'b0, '0, 5'h1f, 1'b1);
      step_keep(1'b1, ha, 5'h00, 1'b0);
      chk("R11 first msg", {msg_req, msg_fatal}, 2'b11);
      step_keep(1'b1, hb, 5'h04, 1'b0);
      chk("R11 pending drops", msg_req, 1'b0);
      chk("R7 sse still set", sts[2], 1'b1);
      step_keep(1'b0, '0, 5'h00, 1'b1);
      chk("R11 ack alone", msg_req, 1'b0);
      step_keep(1'b1, ha, 5'h00, 1'b0);
      chk("R11 after ack", msg_req, 1'b1);
      step_keep(1'b1, hb, 5'h00, 1'b1);
      chk("R11 ack same cycle", msg_req, 1'b1);
      cfg_ude_fatal = 0;
      step_keep(1'b1, hb, 5'h00, 1'b1);
      chk("R11 R6 back to back", {msg_req, msg_fatal}, 2'b10);
      chk("R8 nonfatal", sts[4], 1'b1);
      step(1'b0, '0, 5'h00, 1'b1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule